// File: doc/BRIEF.md
# IDE Transfer Strobe Timer

This block times the command strobes of one IDE channel. A host-side controller hands it a single transfer request per 16-bit word: which drive (master or slave), whether the word moves by PIO or by DMA, and whether it is a read or a write. The block drives the read or write strobe for a number of clock cycles. It then holds the strobe low for a recovery gap and pulses `xfer_done`. Only after that pulse does it take the next request. Back-to-back words are separated only by the recovery gap.

All lengths are counted in clock cycles and come from a 16-bit per-channel timing word. Bit 15 enables the channel. Bits 13:12 and bits 9:8 are inverted two-bit fields that set the fast strobe and fast recovery lengths. Each drive has a four-bit flag group: the master uses bits 3:0 and the slave uses bits 7:4. The flag group decides whether fast timing applies to this kind of transfer and whether the drive's ready line may stretch the strobe. When fast timing does not apply, the block uses a fixed slow, bus-compatible cycle.

Top module: `ide_strobe_timer`

## Requirements
- R1: After reset, both strobes, `busy` and `xfer_done` are low.
- R2: While bit 15 of `timing_word` is 0, a request is ignored: no strobe, `busy` stays low.
- R3: A fast PIO transfer drives its strobe for (inverse of bits 13:12) + 2 cycles, so field 0 gives 5 and field 3 gives 2.
- R4: A fast transfer keeps the strobe low for (inverse of bits 9:8) + 1 recovery cycles, so field 0 gives 4 and field 3 gives 1.
- R5: Within the selected drive's flag group, bit 0 is the fast enable and bit 3 restricts fast timing to DMA. For PIO, fast timing applies only when (group AND 9) equals 1. For DMA, it applies whenever (group AND 9) is nonzero.
- R6: Where fast timing does not apply, the strobe lasts SLOW_STB cycles (default 8) and recovery lasts SLOW_REC cycles (default 6).
- R7: The master's flag group is `timing_word[3:0]` and the slave's is `timing_word[7:4]`, chosen by `req_slave`.
- R8: When bit 1 of the selected group is set, a low `iordy` at the last strobe cycle stretches the strobe one cycle at a time until `iordy` is seen high.
- R9: When bit 1 of the selected group is clear, `iordy` has no effect on the strobe length.
- R10: A read asserts only `rd_stb` and a write asserts only `wr_stb`. The two are never high together.
- R11: `xfer_done` is high for exactly one cycle, in the cycle right after the last recovery cycle. `busy` is high from the strobe through that cycle. A request presented while `busy` is high is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all lengths are counted in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| timing_word | input | 16 | Channel timing and per-drive flag word |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_slave | input | 1 | 1 selects the slave drive, 0 the master |
| req_dma | input | 1 | 1 for a DMA word, 0 for a PIO word |
| req_write | input | 1 | 1 for a write, 0 for a read |
| iordy | input | 1 | Drive ready line |
| rd_stb | output | 1 | Read command strobe, active high |
| wr_stb | output | 1 | Write command strobe, active high |
| busy | output | 1 | A transfer is in progress |
| xfer_done | output | 1 | One-cycle completion pulse |

## Verification
A request sampled at one rising edge raises its strobe in the cycle that follows that edge. The strobe lasts the expected number of cycles, recovery follows for its own count, and `xfer_done` appears in exactly the next cycle. The bench drives inputs and samples outputs on falling edges and counts strobe-high cycles and recovery cycles one at a time. It compares each count with the value it computes from the timing word, and it requires `xfer_done` to fall one cycle after it rises. For the ready line, the bench releases `iordy` in the middle of a chosen strobe cycle, so the stretched length is known to the cycle.

// File: rtl/ide_tim_pkg.sv
// Package: shared types for the IDE strobe timer.
// Assumes: nothing beyond SystemVerilog 2017 packages.
package ide_tim_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STROBE  = 2'd1,
        ST_RECOVER = 2'd2,
        ST_DONE    = 2'd3
    } cyc_state_t;

    // Selected-drive timing decision handed from the decoder to the sequencer.
    typedef struct packed {
        logic fast;
        logic iordy_en;
    } drv_mode_t;
endpackage

// File: rtl/ide_flag_decode.sv
// Module: ide_flag_decode
// Picks the selected drive's flag group from the timing word. Decides whether
// fast timing applies to the requested transfer type and returns the strobe
// and recovery lengths in clock cycles.
// Assumes: SLOW_STB >= 1, SLOW_REC >= 1, and CW is wide enough for every length.
module ide_flag_decode
    import ide_tim_pkg::*;
#(
    parameter int SLOW_STB = 8,
    parameter int SLOW_REC = 6,
    parameter int CW       = 4
) (
    input  logic [15:0]   timing_word,
    input  logic          sel_slave,
    input  logic          sel_dma,
    output drv_mode_t     mode,
    output logic [CW-1:0] stb_len,
    output logic [CW-1:0] rec_len
);
    logic [3:0]    flags;
    logic [CW-1:0] fast_stb;
    logic [CW-1:0] fast_rec;

    // Select the drive's flag group and decide the fast/slow and ready-line modes.
    always_comb begin
        flags         = sel_slave ? timing_word[7:4] : timing_word[3:0];
        mode.iordy_en = flags[1];
        if (sel_dma)
            mode.fast = |(flags & 4'h9);
        else
            mode.fast = ((flags & 4'h9) == 4'h1);
    end

    // Convert the inverted two-bit fields to cycle counts and pick fast or slow.
    always_comb begin
        fast_stb = CW'(2'(~timing_word[13:12])) + CW'(2);
        fast_rec = CW'(2'(~timing_word[9:8]))   + CW'(1);
        stb_len  = mode.fast ? fast_stb : CW'(SLOW_STB);
        rec_len  = mode.fast ? fast_rec : CW'(SLOW_REC);
    end
endmodule

// File: rtl/ide_cycle_seq.sv
// Module: ide_cycle_seq
// Sequencer for one transfer: idle -> strobe -> recovery -> done -> idle.
// Lengths and modes are latched when a request is accepted.
// Assumes: lengths are at least 1; the channel enable is valid when sampled.
module ide_cycle_seq
    import ide_tim_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chan_en,
    input  logic          req_valid,
    input  logic          req_write,
    input  drv_mode_t     mode,
    input  logic [CW-1:0] stb_len,
    input  logic [CW-1:0] rec_len,
    input  logic          iordy,
    output logic          rd_stb,
    output logic          wr_stb,
    output logic          busy,
    output logic          xfer_done
);
    cyc_state_t    state;
    logic [CW-1:0] cnt;
    logic [CW-1:0] rec_hold;
    logic          wr_hold;
    logic          iordy_hold;
    logic          stretch;

    // Hold the strobe at its last cycle while the drive reports not ready.
    always_comb stretch = iordy_hold && !iordy;

    // Advance the transfer state and its cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            rec_hold   <= '0;
            wr_hold    <= 1'b0;
            iordy_hold <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid && chan_en) begin
                        state      <= ST_STROBE;
                        cnt        <= stb_len - CW'(1);
                        rec_hold   <= rec_len;
                        wr_hold    <= req_write;
                        iordy_hold <= mode.iordy_en;
                    end
                end
                ST_STROBE: begin
                    if (cnt != '0) begin
                        cnt <= cnt - CW'(1);
                    end else if (!stretch) begin
                        state <= ST_RECOVER;
                        cnt   <= rec_hold - CW'(1);
                    end
                end
                ST_RECOVER: begin
                    if (cnt != '0)
                        cnt <= cnt - CW'(1);
                    else
                        state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode the outputs from the state.
    always_comb begin
        rd_stb    = (state == ST_STROBE) && !wr_hold;
        wr_stb    = (state == ST_STROBE) &&  wr_hold;
        busy      = (state != ST_IDLE);
        xfer_done = (state == ST_DONE);
    end

    // R10: the two strobes never overlap.
    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb));

    // R11: the done pulse lasts a single cycle.
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    // R11: the done pulse follows recovery directly.
    a_r11_done_after_rec: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_done) |-> $past(state) == ST_RECOVER);

    // R2: an idle block on a disabled channel stays idle.
    a_r2_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !chan_en) |=> !busy);

    // R8: a not-ready drive at the final strobe cycle keeps the strobe up.
    a_r8_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STROBE && cnt == '0 && iordy_hold && !iordy) |=> (rd_stb || wr_stb));

    // R9: with the ready line disabled, the final strobe cycle always ends the strobe.
    a_r9_no_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STROBE && cnt == '0 && !iordy_hold) |=> (state == ST_RECOVER));
endmodule

// File: rtl/ide_strobe_timer.sv
// Module: ide_strobe_timer (top)
// Per-channel IDE strobe timer: decodes the timing word for the requested
// drive and transfer type, then runs the strobe, recovery and done sequence.
// Assumes: the timing word is stable while a transfer is in progress.
module ide_strobe_timer
    import ide_tim_pkg::*;
#(
    parameter int SLOW_STB = 8,
    parameter int SLOW_REC = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] timing_word,
    input  logic        req_valid,
    input  logic        req_slave,
    input  logic        req_dma,
    input  logic        req_write,
    input  logic        iordy,
    output logic        rd_stb,
    output logic        wr_stb,
    output logic        busy,
    output logic        xfer_done
);
    localparam int MAX_STB = (SLOW_STB > 5) ? SLOW_STB : 5;
    localparam int MAX_REC = (SLOW_REC > 4) ? SLOW_REC : 4;
    localparam int MAX_LEN = (MAX_STB > MAX_REC) ? MAX_STB : MAX_REC;
    localparam int CW      = $clog2(MAX_LEN + 1);

    drv_mode_t     mode;
    logic [CW-1:0] stb_len;
    logic [CW-1:0] rec_len;

    ide_flag_decode #(
        .SLOW_STB (SLOW_STB),
        .SLOW_REC (SLOW_REC),
        .CW       (CW)
    ) u_decode (
        .timing_word (timing_word),
        .sel_slave   (req_slave),
        .sel_dma     (req_dma),
        .mode        (mode),
        .stb_len     (stb_len),
        .rec_len     (rec_len)
    );

    ide_cycle_seq #(
        .CW (CW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_en   (timing_word[15]),
        .req_valid (req_valid),
        .req_write (req_write),
        .mode      (mode),
        .stb_len   (stb_len),
        .rec_len   (rec_len),
        .iordy     (iordy),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb),
        .busy      (busy),
        .xfer_done (xfer_done)
    );
endmodule

// File: tb/tb_ide_strobe_timer.sv
module tb_ide_strobe_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] timing_word = 16'h0;
    logic        req_valid = 1'b0;
    logic        req_slave = 1'b0;
    logic        req_dma = 1'b0;
    logic        req_write = 1'b0;
    logic        iordy = 1'b1;
    logic        rd_stb, wr_stb, busy, xfer_done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ide_strobe_timer dut (
        .clk(clk), .rst_n(rst_n), .timing_word(timing_word),
        .req_valid(req_valid), .req_slave(req_slave), .req_dma(req_dma),
        .req_write(req_write), .iordy(iordy),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .busy(busy), .xfer_done(xfer_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected fast decision from R5/R7.
    function automatic bit exp_fast(input logic [15:0] tw, input bit slv, input bit dma);
        logic [3:0] g = slv ? tw[7:4] : tw[3:0];
        if (dma) return (g & 4'h9) != 0;
        return (g & 4'h9) == 4'h1;
    endfunction

    function automatic int exp_stb(input logic [15:0] tw, input bit slv, input bit dma);
        if (!exp_fast(tw, slv, dma)) return 8;
        return int'(~tw[13:12] & 2'b11) + 2;
    endfunction

    function automatic int exp_rec(input logic [15:0] tw, input bit slv, input bit dma);
        if (!exp_fast(tw, slv, dma)) return 6;
        return int'(~tw[9:8] & 2'b11) + 1;
    endfunction

    // One transfer; rel>0 releases iordy after strobe cycle rel; poke retries a request while busy.
    task automatic xfer(input string req, input logic [15:0] tw, input bit slv,
                        input bit dma, input bit wr, input bit iordy_lvl,
                        input int rel, input int exp_s, input int exp_r, input bit poke);
        int sc = 0;
        int rc = 0;
        int bad = 0;
        @(negedge clk);
        timing_word = tw; req_slave = slv; req_dma = dma; req_write = wr;
        iordy = iordy_lvl; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while ((rd_stb || wr_stb) && sc < 200) begin
            sc++;
            if (rd_stb && wr_stb) bad++;
            if (wr ? !wr_stb : !rd_stb) bad++;
            if (sc == rel) iordy = 1'b1;
            @(negedge clk);
        end
        while (busy && !xfer_done && rc < 200) begin
            rc++;
            req_valid = poke && (rc == 1);
            @(negedge clk);
            req_valid = 1'b0;
        end
        chk(sc == exp_s, req, "strobe cycles", sc, exp_s);
        chk(rc == exp_r, req, "recovery cycles", rc, exp_r);
        chk(bad == 0, "R10", "wrong strobe cycles", bad, 0);
        chk(xfer_done == 1'b1, "R11", "done after recovery", int'(xfer_done), 1);
        @(negedge clk);
        chk(!xfer_done && !busy, "R11", "done single cycle/idle", int'(xfer_done | busy), 0);
        if (poke) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                chk(!busy && !rd_stb && !wr_stb, "R11", "request during busy dropped",
                    int'(busy), 0);
            end
        end
        iordy = 1'b1;
    endtask

    task automatic t_reset();
        chk(!rd_stb && !wr_stb && !busy && !xfer_done, "R1", "reset outputs",
            int'({rd_stb, wr_stb, busy, xfer_done}), 0);
    endtask

    task automatic t_disabled();
        @(negedge clk);
        timing_word = 16'h7F11; req_slave = 1'b0; req_dma = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            chk(!busy && !rd_stb && !wr_stb, "R2", "disabled channel idle", int'(busy), 0);
            @(negedge clk);
        end
    endtask

    task automatic t_fast_pio();
        logic [15:0] tw;
        tw = 16'h8001; // fields 0 -> 5/4
        xfer("R3", tw, 0, 0, 0, 1, 0, exp_stb(tw, 0, 0), exp_rec(tw, 0, 0), 0);
        tw = 16'hB301; // fields 3 -> 2/1
        xfer("R4", tw, 0, 0, 1, 1, 0, exp_stb(tw, 0, 0), exp_rec(tw, 0, 0), 0);
        tw = 16'h9201; // fields 1/2 -> 4/2
        xfer("R3", tw, 0, 0, 0, 1, 0, 4, 2, 0);
    endtask

    task automatic t_dma_modes();
        logic [15:0] tw;
        tw = 16'h8009; // PIO with DMA-only bit -> slow
        xfer("R6", tw, 0, 0, 0, 1, 0, 8, 6, 0);
        xfer("R5", tw, 0, 1, 0, 1, 0, exp_stb(tw, 0, 1), exp_rec(tw, 0, 1), 0);
        tw = 16'h8008; // DMA with only bit 3 -> fast
        xfer("R5", tw, 0, 1, 1, 1, 0, 5, 4, 0);
        tw = 16'h8004; // no fast bits -> slow DMA
        xfer("R6", tw, 0, 1, 0, 1, 0, 8, 6, 0);
    endtask

    task automatic t_slave();
        logic [15:0] tw;
        tw = 16'hA110; // slave fast, master slow
        xfer("R7", tw, 1, 0, 0, 1, 0, exp_stb(tw, 1, 0), exp_rec(tw, 1, 0), 0);
        xfer("R7", tw, 0, 0, 1, 1, 0, 8, 6, 0);
    endtask

    task automatic t_iordy();
        logic [15:0] tw;
        tw = 16'h8003; // fast + ready line, strobe 5
        xfer("R8", tw, 0, 0, 0, 0, 8, 8, 4, 0);
        xfer("R8", tw, 0, 0, 1, 0, 5, 5, 4, 0);
        tw = 16'h8001; // ready line disabled, iordy held low
        xfer("R9", tw, 0, 0, 0, 0, 0, 5, 4, 0);
    endtask

    task automatic t_busy_drop();
        xfer("R11", 16'h8001, 0, 0, 1, 1, 0, 5, 4, 1);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_fast_pio();
        t_dma_modes();
        t_slave();
        t_iordy();
        t_busy_drop();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule